// File: doc/BRIEF.md
# Run-time Polynomial Nibble CRC-16 Register

This block holds a 16-bit cyclic-redundancy state and folds one 4-bit data nibble into it on each clock where the data-valid flag is high. The generator polynomial is an input port, not a constant. Software or a neighbouring block can therefore select or change the polynomial between any two nibbles, and the change takes effect on the very next update. The next state is produced by one pure function of the present state, the polynomial and the nibble. That function runs the four bit steps as straight-line logic, and the clocked process calls it, so the update path contains no combinational loop.

A synchronous reset forces the state to zero. A synchronous clear loads a caller-supplied seed, which is typically all ones for checksum use. Between nibbles the state holds its value, so a stream can arrive with gaps.

Top module: `polycrc_nib_reg`

## Requirements
- R1: While `rst` is high at a rising edge, the state becomes 0x0000 after that edge, whatever the other inputs are.
- R2: With `rst` low and `clr` high at a rising edge, `crc_q` equals the `seed` value sampled at that edge.
- R3: `clr` takes priority over `valid`: when both are high, the seed is loaded and the nibble is discarded.
- R4: With `rst`, `clr` and `valid` all low at a rising edge, `crc_q` keeps its previous value.
- R5: A valid nibble is absorbed most significant bit first. For each bit b (3 down to 0), feedback f = data[b] XOR state[15], then state = (state << 1) XOR (f ? poly : 0).
- R6: The `poly` value sampled at each update edge is the value used, so a polynomial change between consecutive nibbles applies from the next nibble on.
- R7: Exactly one nibble is absorbed per valid edge, and the result is visible on `crc_q` directly after that edge, with no further latency.
- R8: With `poly` equal to zero, a valid update yields the previous state shifted left by four bits, with zeros filling the low bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; forces state to zero |
| clr | input | 1 | Synchronous clear; loads `seed` |
| seed | input | 16 | Value loaded by `clr` |
| valid | input | 1 | Absorb `data` on this edge |
| data | input | 4 | Data nibble, bit 3 processed first |
| poly | input | 16 | Generator polynomial (implicit x^16 term) |
| crc_q | output | 16 | Registered CRC state |

## Verification
On every cycle, the bound assertions check reset to zero, seed loading, the clear-over-valid priority, holding while idle, and the pure four-bit shift under a zero polynomial. The arithmetic of the update under non-zero polynomials, and polynomials that change between nibbles, can be shown only by the bench. The bench compares each cycle's state against an independent bit-serial model over fixed and random polynomial and data streams that include gaps and clears.

// File: rtl/polycrc_pkg.sv
package polycrc_pkg;
  // Operation chosen for the state register on the coming edge
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_SEED = 2'd1,
    OP_STEP = 2'd2,
    OP_ZERO = 2'd3
  } crc_op_e;
endpackage

// File: rtl/polycrc_ctrl.sv
module polycrc_ctrl
  import polycrc_pkg::*;
(
  input  logic    rst,
  input  logic    clr,
  input  logic    valid,
  output crc_op_e op
);
  // Fixed priority: reset, then clear, then data update
  always_comb begin
    if (rst)        op = OP_ZERO;
    else if (clr)   op = OP_SEED;
    else if (valid) op = OP_STEP;
    else            op = OP_HOLD;
  end
endmodule

// File: rtl/polycrc_reg.sv
module polycrc_reg
  import polycrc_pkg::*;
#(
  parameter int STATE_W = 16,
  parameter int NIB_W   = 4
) (
  input  logic               clk,
  input  crc_op_e            op,
  input  logic [STATE_W-1:0] seed,
  input  logic [STATE_W-1:0] poly,
  input  logic [NIB_W-1:0]   data,
  output logic [STATE_W-1:0] crc_q
);
  localparam int MSB = STATE_W - 1;

  // Unrolled fold of one nibble, MSB first; no feedback outside the flop
  function automatic logic [STATE_W-1:0] absorb(
    input logic [STATE_W-1:0] st,
    input logic [STATE_W-1:0] gp,
    input logic [NIB_W-1:0]   nib
  );
    logic [STATE_W-1:0] acc;
    logic               fb;
    acc = st;
    for (int b = NIB_W - 1; b >= 0; b--) begin
      fb  = nib[b] ^ acc[MSB];
      acc = {acc[MSB-1:0], 1'b0} ^ (gp & {STATE_W{fb}});
    end
    return acc;
  endfunction

  always_ff @(posedge clk) begin
    case (op)
      OP_ZERO: crc_q <= '0;
      OP_SEED: crc_q <= seed;
      OP_STEP: crc_q <= absorb(crc_q, poly, data);
      default: crc_q <= crc_q;
    endcase
  end
endmodule

// File: rtl/polycrc_nib_reg.sv
module polycrc_nib_reg
  import polycrc_pkg::*;
#(
  parameter int STATE_W = 16,
  parameter int NIB_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic [STATE_W-1:0] seed,
  input  logic               valid,
  input  logic [NIB_W-1:0]   data,
  input  logic [STATE_W-1:0] poly,
  output logic [STATE_W-1:0] crc_q
);
  crc_op_e op;

  polycrc_ctrl u_ctrl (
    .rst   (rst),
    .clr   (clr),
    .valid (valid),
    .op    (op)
  );

  polycrc_reg #(
    .STATE_W (STATE_W),
    .NIB_W   (NIB_W)
  ) u_reg (
    .clk   (clk),
    .op    (op),
    .seed  (seed),
    .poly  (poly),
    .data  (data),
    .crc_q (crc_q)
  );
endmodule

// File: rtl/polycrc_nib_reg_chk.sv
module polycrc_nib_reg_chk #(
  parameter int STATE_W = 16,
  parameter int NIB_W   = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               clr,
  input logic [STATE_W-1:0] seed,
  input logic               valid,
  input logic [NIB_W-1:0]   data,
  input logic [STATE_W-1:0] poly,
  input logic [STATE_W-1:0] crc_q
);
  logic seen = 1'b0;
  always_ff @(posedge clk) seen <= 1'b1;

  assert_reset_zero_R1: assert property (@(posedge clk)
    seen && $past(rst) |-> crc_q == '0);

  assert_clear_seed_R2: assert property (@(posedge clk) disable iff (rst)
    $past(clr) && !$past(rst) |-> crc_q == $past(seed));

  assert_clear_wins_R3: assert property (@(posedge clk) disable iff (rst)
    $past(clr) && $past(valid) && !$past(rst) |-> crc_q == $past(seed));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(clr) && !$past(valid) |-> $stable(crc_q));

  assert_zero_poly_shift_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(clr) && $past(valid) && $past(poly) == '0
      |-> crc_q == ($past(crc_q) << NIB_W));
endmodule

bind polycrc_nib_reg polycrc_nib_reg_chk #(
  .STATE_W (STATE_W),
  .NIB_W   (NIB_W)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .clr   (clr),
  .seed  (seed),
  .valid (valid),
  .data  (data),
  .poly  (poly),
  .crc_q (crc_q)
);

// File: tb/polycrc_nib_reg_tb_top.sv
module polycrc_nib_reg_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr = 1'b0;
  logic [15:0] seed = '0;
  logic        valid = 1'b0;
  logic [3:0]  data = '0;
  logic [15:0] poly = '0;
  logic [15:0] crc_q;

  always #(CLK_P/2) clk = ~clk;

  polycrc_nib_reg dut_i (
    .clk(clk), .rst(rst), .clr(clr), .seed(seed),
    .valid(valid), .data(data), .poly(poly), .crc_q(crc_q)
  );

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  logic [15:0] model = '0;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  // Independent bit-serial reference: one bit at a time, MSB first
  function automatic logic [15:0] ref_bit(input logic [15:0] s, input logic [15:0] p, input logic d);
    logic top;
    top = s[15];
    s   = s << 1;
    if (top != d) s = s ^ p;
    return s;
  endfunction

  task automatic drive(input bit r, input bit c, input logic [15:0] sd,
                       input bit v, input logic [3:0] d, input logic [15:0] p, input string tag);
    item_t it;
    @(negedge clk);
    rst = r; clr = c; seed = sd; valid = v; data = d; poly = p;
    if (r)      model = 16'h0000;
    else if (c) model = sd;
    else if (v) for (int b = 3; b >= 0; b--) model = ref_bit(model, p, d[b]);
    it.exp = model;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: result of each edge is compared just after that edge (R7)
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (crc_q !== it.exp) begin
          fails++;
          $display("FAIL %s: crc_q=%h expected=%h", it.tag, crc_q, it.exp);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] p;
    // R1: reset, also with clr and valid active
    drive(1, 0, 16'h0, 0, 4'h0, 16'h0, "R1");
    drive(1, 1, 16'hBEEF, 1, 4'hF, 16'h1021, "R1");
    // R2: seed loads
    drive(0, 1, 16'hFFFF, 0, 4'h0, 16'h1021, "R2");
    drive(0, 1, 16'h1234, 0, 4'h0, 16'h1021, "R2");
    // R5: fixed polynomial stream
    drive(0, 0, 16'h0, 1, 4'hA, 16'h1021, "R5");
    drive(0, 0, 16'h0, 1, 4'h5, 16'h1021, "R5");
    drive(0, 0, 16'h0, 1, 4'hF, 16'h8005, "R6");
    drive(0, 0, 16'h0, 1, 4'h0, 16'h3D65, "R6");
    // R4: gaps hold, even as data and poly move
    drive(0, 0, 16'hAAAA, 0, 4'h7, 16'hFFFF, "R4");
    drive(0, 0, 16'h5555, 0, 4'h9, 16'h0001, "R4");
    // R3: clear beats valid
    drive(0, 1, 16'hC0DE, 1, 4'hF, 16'h1021, "R3");
    // R8: zero polynomial is a pure shift
    drive(0, 1, 16'h1234, 0, 4'h0, 16'h0, "R2");
    drive(0, 0, 16'h0, 1, 4'h0, 16'h0, "R8");
    drive(0, 0, 16'h0, 1, 4'hF, 16'h0, "R8");
    // R5/R6: random polynomials and data, random gaps and clears
    for (int i = 0; i < 400; i++) begin
      p = 16'($urandom);
      if ((i % 37) == 0)
        drive(0, 1, 16'($urandom), ($urandom % 2) == 1, 4'($urandom), p, "R3");
      else if ((i % 5) == 0)
        drive(0, 0, 16'($urandom), 0, 4'($urandom), p, "R4");
      else
        drive(0, 0, 16'($urandom), 1, 4'($urandom), (i % 3 == 0) ? 16'h1021 : p, "R6");
    end
    // R1: reset mid-stream
    drive(1, 0, 16'h0, 1, 4'hC, 16'h1021, "R1");
    drive(0, 0, 16'h0, 0, 4'h0, 16'h1021, "R4");
    @(negedge clk);
    valid = 1'b0; clr = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule